// File: doc/BRIEF.md
# FIFO Occupancy Busy Monitor

This block watches the fill levels of the readout FIFOs that sit in front of an event builder. There are three classes of FIFO: one data FIFO per input link, one management FIFO per input link, and a single timing-data FIFO. Each class has its own programmable limit. When any FIFO holds more entries than its class limit, an internal busy flag is raised. The flag drops once every FIFO is back at or below its limit.

The block does not drive the busy level straight to the trigger source. It reports each change of the flag as a message toward an output link: an activate message when the flag rises and a deactivate message when it falls. Messages wait in a small pending store until the link takes them through a ready/valid handshake. This lets upstream triggers be paused and resumed without losing a transition, even when the link is briefly not ready.

Top module: `fifo_busy_monitor`

## Requirements
- R1: All FIFOs of one class are compared against that class's single limit input, whatever link position they sit at.
- R2: `busy_o` becomes 1 on the clock edge after any occupancy is strictly greater than its class limit. It becomes 0 on the edge after none is.
- R3: An occupancy equal to its limit never sets busy.
- R4: An activate message (`act_o`=1) is offered only as the result of a 0→1 change of the busy flag. `act_o` and `deact_o` are never both 1.
- R5: A deactivate message (`deact_o`=1) is offered only as the result of a 1→0 change of the busy flag.
- R6: A message is consumed on a clock edge where `msg_valid_o` and `msg_ready_i` are both 1. While `msg_ready_i` is 0, the offered message is held unchanged. Messages are delivered in the order of the flag changes that caused them. A message appears in the same cycle as the `busy_o` change that caused it.
- R7: At most `MAX_PEND` messages are pending. A change that arrives while the store is full cancels the newest pending message, which is the opposite kind. The delivered sequence therefore still alternates and ends on the current busy state.
- R8: A new limit value takes effect on the next clock edge.
- R9: After reset, `busy_o`, `msg_valid_o`, `act_o` and `deact_o` are 0.
- R10: The monitored set is `N_LINKS` (default 12) data FIFOs, `N_LINKS` management FIFOs and one timing FIFO. Link i occupies bits [i*OCC_W +: OCC_W] of the flat occupancy buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_occ_i | input | N_LINKS*OCC_W | Data FIFO occupancies, link i at [i*OCC_W +: OCC_W] |
| mgmt_occ_i | input | N_LINKS*OCC_W | Management FIFO occupancies, same layout |
| tmg_occ_i | input | OCC_W | Timing FIFO occupancy |
| data_lim_i | input | OCC_W | Limit shared by all data FIFOs |
| mgmt_lim_i | input | OCC_W | Limit shared by all management FIFOs |
| tmg_lim_i | input | OCC_W | Limit for the timing FIFO |
| msg_ready_i | input | 1 | Output link can take a message |
| busy_o | output | 1 | Registered busy flag |
| msg_valid_o | output | 1 | A message is offered |
| act_o | output | 1 | Offered message is busy-activate |
| deact_o | output | 1 | Offered message is busy-deactivate |

## Verification
The comparison is swept exhaustively over a 4-bit configuration. For every class, every limit is paired with every occupancy, and the occupancy is placed at rotating link positions. This separates a strict from a non-strict compare, shows a limit being used by the wrong class, and catches a link position that is ignored. During the sweep the link is always ready. Each step is checked for the exact strobe implied by the previous and new busy state, so a missing or spurious message shows up at once.

A pattern with two FIFOs over their limits at once, released one at a time, shows that busy is an OR across the set. A backpressured pattern toggles busy three times with the link stalled, then drains; this checks holding and ordering. Five toggles against a store of four check that the overflow cancellation keeps the delivered sequence alternating and ending on the final state.

// File: rtl/busy_mon_pkg.sv
package busy_mon_pkg;

  // Strict over-limit test shared by every comparator lane.
  function automatic logic occ_exceeds(input logic [31:0] occ, input logic [31:0] lim);
    return occ > lim;
  endfunction

  // Kind of the next message after the head has been taken (kinds alternate).
  function automatic logic next_kind(input logic head_is_act);
    return ~head_is_act;
  endfunction

endpackage

// File: rtl/occ_class_cmp.sv
module occ_class_cmp #(
  parameter int N_FIFO = 12,
  parameter int OCC_W  = 10
) (
  input  logic [N_FIFO*OCC_W-1:0] occ_i,
  input  logic [OCC_W-1:0]        lim_i,
  output logic [N_FIFO-1:0]       over_vec_o,
  output logic                    any_over_o
);
  import busy_mon_pkg::*;

  for (genvar g = 0; g < N_FIFO; g++) begin : g_lane
    assign over_vec_o[g] = occ_exceeds(32'(occ_i[g*OCC_W +: OCC_W]), 32'(lim_i));
  end

  assign any_over_o = |over_vec_o;
endmodule

// File: rtl/busy_tracker.sv
module busy_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic any_over_i,
  output logic busy_o,
  output logic rise_o,
  output logic fall_o
);
  logic busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= any_over_i;
  end

  assign rise_o = any_over_i & ~busy_q;
  assign fall_o = ~any_over_i & busy_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/busy_msg_queue.sv
module busy_msg_queue #(
  parameter int MAX_PEND = 8,
  parameter int PEND_W   = $clog2(MAX_PEND + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic              act_o,
  output logic              deact_o,
  output logic [PEND_W-1:0] pend_cnt_o
);
  import busy_mon_pkg::*;

  localparam logic [PEND_W-1:0] CNT_MAX = PEND_W'(MAX_PEND);
  localparam logic [PEND_W-1:0] CNT_ONE = PEND_W'(1);

  logic [PEND_W-1:0] cnt_q, cnt_d;
  logic              head_q, head_d;
  logic              push, pop;

  assign push = rise_i | fall_i;
  assign pop  = valid_o & ready_i;

  always_comb begin
    cnt_d  = cnt_q;
    head_d = head_q;
    if (push && cnt_q == '0) begin
      cnt_d  = CNT_ONE;
      head_d = rise_i;
    end else if (pop && push) begin
      head_d = next_kind(head_q);
    end else if (pop) begin
      cnt_d  = cnt_q - CNT_ONE;
      head_d = next_kind(head_q);
    end else if (push) begin
      // full store: new change cancels the newest (opposite) pending entry
      cnt_d = (cnt_q == CNT_MAX) ? cnt_q - CNT_ONE : cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      head_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      head_q <= head_d;
    end
  end

  assign valid_o    = (cnt_q != '0);
  assign act_o      = valid_o & head_q;
  assign deact_o    = valid_o & ~head_q;
  assign pend_cnt_o = cnt_q;
endmodule

// File: rtl/fifo_busy_monitor.sv
module fifo_busy_monitor #(
  parameter int N_LINKS  = 12,
  parameter int OCC_W    = 10,
  parameter int MAX_PEND = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_LINKS*OCC_W-1:0] data_occ_i,
  input  logic [N_LINKS*OCC_W-1:0] mgmt_occ_i,
  input  logic [OCC_W-1:0]         tmg_occ_i,
  input  logic [OCC_W-1:0]         data_lim_i,
  input  logic [OCC_W-1:0]         mgmt_lim_i,
  input  logic [OCC_W-1:0]         tmg_lim_i,
  input  logic                     msg_ready_i,
  output logic                     busy_o,
  output logic                     msg_valid_o,
  output logic                     act_o,
  output logic                     deact_o
);
  localparam int PEND_W = $clog2(MAX_PEND + 1);

  logic [N_LINKS-1:0] data_over_vec, mgmt_over_vec;
  logic [0:0]         tmg_over_vec;
  logic               data_over, mgmt_over, tmg_over;
  logic               any_over;
  logic               busy_rise, busy_fall;
  logic [PEND_W-1:0]  pend_cnt;

  occ_class_cmp #(.N_FIFO(N_LINKS), .OCC_W(OCC_W)) u_data_cmp (
    .occ_i(data_occ_i), .lim_i(data_lim_i),
    .over_vec_o(data_over_vec), .any_over_o(data_over));

  occ_class_cmp #(.N_FIFO(N_LINKS), .OCC_W(OCC_W)) u_mgmt_cmp (
    .occ_i(mgmt_occ_i), .lim_i(mgmt_lim_i),
    .over_vec_o(mgmt_over_vec), .any_over_o(mgmt_over));

  occ_class_cmp #(.N_FIFO(1), .OCC_W(OCC_W)) u_tmg_cmp (
    .occ_i(tmg_occ_i), .lim_i(tmg_lim_i),
    .over_vec_o(tmg_over_vec), .any_over_o(tmg_over));

  assign any_over = data_over | mgmt_over | tmg_over;

  busy_tracker u_tracker (
    .clk(clk), .rst_n(rst_n), .any_over_i(any_over),
    .busy_o(busy_o), .rise_o(busy_rise), .fall_o(busy_fall));

  busy_msg_queue #(.MAX_PEND(MAX_PEND), .PEND_W(PEND_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .rise_i(busy_rise), .fall_i(busy_fall),
    .ready_i(msg_ready_i), .valid_o(msg_valid_o), .act_o(act_o),
    .deact_o(deact_o), .pend_cnt_o(pend_cnt));
endmodule

// File: rtl/busy_mon_checker.sv
module busy_mon_checker #(
  parameter int MAX_PEND = 8,
  parameter int PEND_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              any_over,
  input logic              busy_o,
  input logic              msg_valid_o,
  input logic              act_o,
  input logic              deact_o,
  input logic              msg_ready_i,
  input logic [PEND_W-1:0] pend_cnt
);
  AST_BUSY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    any_over |=> busy_o); // R2
  AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !any_over |=> !busy_o); // R2
  AST_CHANGE_MAKES_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_o) || $fell(busy_o)) |-> msg_valid_o); // R4
  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_o && deact_o)); // R4
  AST_KIND_WHEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o |-> $onehot0({act_o, deact_o}) && (act_o || deact_o)); // R5
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(act_o))); // R6
  AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= PEND_W'(MAX_PEND)); // R7
endmodule

bind fifo_busy_monitor busy_mon_checker #(.MAX_PEND(MAX_PEND), .PEND_W(PEND_W)) u_busy_chk (
  .clk(clk), .rst_n(rst_n), .any_over(any_over), .busy_o(busy_o),
  .msg_valid_o(msg_valid_o), .act_o(act_o), .deact_o(deact_o),
  .msg_ready_i(msg_ready_i), .pend_cnt(pend_cnt));

// File: tb/test_fifo_busy_monitor.sv
module test_fifo_busy_monitor;
  localparam int N  = 12;
  localparam int W  = 4;
  localparam int MP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N*W-1:0] data_occ = '0, mgmt_occ = '0;
  logic [W-1:0]   tmg_occ = '0, data_lim = '1, mgmt_lim = '1, tmg_lim = '1;
  logic           ready = 1'b1;
  logic           busy, valid, act, deact;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fifo_busy_monitor #(.N_LINKS(N), .OCC_W(W), .MAX_PEND(MP)) i_fifo_busy_monitor (
    .clk(clk), .rst_n(rst_n), .data_occ_i(data_occ), .mgmt_occ_i(mgmt_occ),
    .tmg_occ_i(tmg_occ), .data_lim_i(data_lim), .mgmt_lim_i(mgmt_lim),
    .tmg_lim_i(tmg_lim), .msg_ready_i(ready), .busy_o(busy),
    .msg_valid_o(valid), .act_o(act), .deact_o(deact));

  // over-limit when lim - occ borrows
  function automatic bit borrow_over(input logic [W-1:0] o, input logic [W-1:0] l);
    logic [W:0] d;
    d = {1'b0, l} - {1'b0, o};
    return d[W];
  endfunction

  function automatic bit model_busy();
    bit b = 0;
    for (int i = 0; i < N; i++) begin
      b |= borrow_over(data_occ[i*W +: W], data_lim);
      b |= borrow_over(mgmt_occ[i*W +: W], mgmt_lim);
    end
    b |= borrow_over(tmg_occ, tmg_lim);
    return b;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int a, input int e);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, a, e);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // checks the offered message kind: 0 none, 1 activate, 2 deactivate
  task automatic chk_msg(input string req, input int exp_kind);
    int got;
    got = !valid ? 0 : (act && !deact) ? 1 : (deact && !act) ? 2 : 3;
    chk(got == exp_kind, req, "message kind", got, exp_kind);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit prev, exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(busy == 0, "R9", "busy after reset", busy, 0);
    chk_msg("R9", 0);

    // R1 R2 R3 R4 R5 R8 R10: exhaustive class/limit/occupancy sweep, ready held high
    prev = 0;
    for (int cls = 0; cls < 3; cls++) begin
      for (int l = 0; l < 16; l++) begin
        for (int v = 0; v < 16; v++) begin
          int p;
          p = (l * 5 + v) % N;
          data_occ = '0; mgmt_occ = '0; tmg_occ = '0;
          data_lim = '1; mgmt_lim = '1; tmg_lim = '1;
          case (cls)
            0: begin data_lim = W'(l); data_occ[p*W +: W] = W'(v); end
            1: begin mgmt_lim = W'(l); mgmt_occ[p*W +: W] = W'(v); end
            default: begin tmg_lim = W'(l); tmg_occ = W'(v); end
          endcase
          exp = model_busy();
          tick();
          chk(busy == exp, (v == l) ? "R3" : "R2 R1 R8 R10", "busy in sweep", busy, exp);
          chk_msg((exp && !prev) ? "R4" : "R5", (exp && !prev) ? 1 : (!exp && prev) ? 2 : 0);
          prev = exp;
        end
      end
    end
    data_occ = '0; mgmt_occ = '0; tmg_occ = '0;
    data_lim = 4'd3; mgmt_lim = 4'd3; tmg_lim = 4'd3;
    tick(); tick();

    // R2: two FIFOs over, release one at a time
    data_occ[2*W +: W] = 4'd9; mgmt_occ[7*W +: W] = 4'd9;
    tick();
    chk(busy == 1, "R2", "busy with two over", busy, 1);
    chk_msg("R4", 1);
    data_occ = '0;
    tick();
    chk(busy == 1, "R2", "busy with one still over", busy, 1);
    chk_msg("R5", 0);
    mgmt_occ = '0;
    tick();
    chk(busy == 0, "R2", "busy after both released", busy, 0);
    chk_msg("R5", 2);
    tick();

    // R8: limit change alone
    tmg_occ = 4'd5; tmg_lim = 4'd5;
    tick();
    chk(busy == 0, "R3", "equal to limit", busy, 0);
    tmg_lim = 4'd4;
    tick();
    chk(busy == 1, "R8", "limit lowered", busy, 1);
    tmg_lim = 4'd5;
    tick();
    chk(busy == 0, "R8", "limit restored", busy, 0);
    tick();
    chk_msg("R6", 0);

    // R6: stalled link, three changes, then drain in order
    ready = 0;
    tmg_occ = 4'd9; tick();
    tmg_occ = 4'd0; tick();
    tmg_occ = 4'd9; tick();
    chk_msg("R6", 1);
    tick();
    chk_msg("R6", 1);
    ready = 1;
    #1 chk_msg("R6", 1);
    tick(); chk_msg("R6", 2);
    tick(); chk_msg("R6", 1);
    tick(); chk_msg("R6", 0);
    chk(busy == 1, "R6", "busy while draining", busy, 1);
    tmg_occ = 4'd0; tick(); tick();

    // R7: five changes against a store of four
    ready = 0;
    for (int k = 0; k < 5; k++) begin
      tmg_occ = (k % 2 == 0) ? 4'd9 : 4'd0;
      tick();
    end
    chk(busy == 1, "R7", "busy after five changes", busy, 1);
    ready = 1;
    #1 chk_msg("R7", 1);
    tick(); chk_msg("R7", 2);
    tick(); chk_msg("R7", 1);
    tick(); chk_msg("R7", 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule